// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one 16-bit down-counting channel of a three-channel interval timer. Software programs it with an 8-bit control word and moves the count one byte at a time through a data port. The counting itself advances only on a count-enable pulse, nominally at 1.19318 MHz, that arrives alongside the fast system clock. The channel drives a single output pin. Depending on the programmed mode, that pin acts as a terminal-count flag, a rate-generator strobe or a square wave.

Each channel instance answers only to control words whose select field equals its `CHAN_ID` parameter. Loads are always low byte then high byte, and reads alternate in the same order. A latch command freezes a snapshot of the count so that a running channel can be read coherently. Control words the channel cannot honour are dropped, and they raise a sticky error flag.

The port is a plain register interface. Each strobe acts on one clock edge and is always accepted, so there is no back-pressure. Read data is combinational from the current state while `data_rd` is high, and the read pointer advances on the edge that ends the strobe cycle.

Top module: `pit_channel`

## Requirements
- R1: After reset the output pin and the error flag are low, the count is zero, both byte pointers are at the low byte and no latch is held.
- R2: Control word fields are: select in bits 7:6, access in bits 5:4, mode in bits 3:1 and BCD in bit 0. A word whose select equals `CHAN_ID` with access 11, BCD 0 and mode 000, 010 or 011 sets the mode. A word whose select is another channel number (not 11) is ignored and raises no error.
- R3: A word for this channel with access 01 or 10, with BCD 1, or with any other mode value, and any word with select 11, is ignored and sets `cfg_err`. `cfg_err` stays high until reset.
- R4: A data write while the write pointer is at the low byte replaces count bits 7:0, stops counting, drives the output low on the next cycle and moves the write pointer to the high byte.
- R5: A data write at the high byte replaces count bits 15:8, stores the full count as the reload period and returns the pointer to the low byte. Counting starts only if that value is nonzero. In modes 010 and 011 a nonzero start drives the output high.
- R6: Reads with no latch held return the live count, low byte first and then high byte, alternating.
- R7: An access-00 word for this channel copies the live count into a hold register, sets the read pointer to the low byte and marks a latch held. A latch command while one is held has no effect. While a latch is held, reads return the held value, and the high-byte read releases it.
- R8: Mode 000: each count enable decrements the count. The enable that takes it from 1 to 0 drives the output high and stops counting, and the count then holds at 0.
- R9: Mode 010: an enable at count 1 reloads the period and drives the output low. Any other enable decrements the count and drives the output high, so the low pulse lasts one count interval.
- R10: Mode 011: an enable at count 2 or less reloads the period and toggles the output. Any other enable subtracts 2. The output therefore toggles every ceil(period/2) enables.
- R11: The count changes only on an enable while counting, or on a data write. A data write in the same cycle as an enable takes precedence, and that enable is lost.
- R12: The read and write byte pointers are independent. Reads between the two load bytes do not disturb the load sequence, and loads do not move the read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | Count enable, one clock wide per count interval |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_word | input | 8 | Control word |
| data_wr | input | 1 | Data port write strobe |
| data_rd | input | 1 | Data port read strobe |
| wr_byte | input | BYTE_W | Data port write byte |
| rd_byte | output | BYTE_W | Data port read byte (valid while data_rd is high) |
| out_pin | output | 1 | Channel output |
| cfg_err | output | 1 | Sticky invalid-control-word flag |

## Verification
The bench builds the channel with `CHAN_ID` = 2 and the default `BYTE_W` of 8. With that setting, words aimed at channels 0 and 1 must pass silently, and select 11 must be flagged. A default instance would hide a decoder that ignores the select field. Small random load values bring terminal count, reload and square-wave toggling within a few enables. Random latch and read interleavings reach the double-latch and pointer-independence cases.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam int PIT_BYTE_W = 8;

  typedef enum logic [2:0] {
    PM_TC   = 3'b000,
    PM_RATE = 3'b010,
    PM_SQW  = 3'b011
  } pit_mode_e;

  typedef struct packed {
    logic [1:0] sel;
    logic [1:0] acc;
    logic [2:0] mode;
    logic       bcd;
  } pit_cw_t;

  localparam logic [1:0] ACC_LATCH = 2'b00;
  localparam logic [1:0] ACC_LOHI  = 2'b11;
  localparam logic [1:0] SEL_RDBK  = 2'b11;

endpackage

// File: rtl/pit_cw_decode.sv
module pit_cw_decode
  import pit_pkg::*;
#(
  parameter int CHAN_ID = 0
) (
  input  logic      cw_wr,
  input  pit_cw_t   cw,
  output logic      latch_req,
  output logic      prog_req,
  output pit_mode_e prog_mode,
  output logic      cw_bad
);

  logic ours;
  logic mode_ok;

  always_comb begin
    ours      = (cw.sel == 2'(CHAN_ID));
    mode_ok   = (cw.mode == PM_TC) || (cw.mode == PM_RATE) || (cw.mode == PM_SQW);
    prog_mode = pit_mode_e'(cw.mode);
    latch_req = 1'b0;
    prog_req  = 1'b0;
    cw_bad    = 1'b0;
    if (cw_wr) begin
      if (cw.sel == SEL_RDBK) begin
        cw_bad = 1'b1;
      end else if (ours) begin
        if (cw.acc == ACC_LATCH) begin
          latch_req = 1'b1;
        end else if (cw.acc == ACC_LOHI && !cw.bcd && mode_ok) begin
          prog_req = 1'b1;
        end else begin
          cw_bad = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              prog_req,
  input  pit_mode_e         prog_mode,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [CNT_W-1:0]  count,
  output logic              out_pin,
  output logic              running,
  output logic              wr_hi,
  output pit_mode_e         mode_q
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] full_load;

  assign full_load = {wr_byte, count[BYTE_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= ZERO;
      period  <= ZERO;
      out_pin <= 1'b0;
      running <= 1'b0;
      wr_hi   <= 1'b0;
      mode_q  <= PM_TC;
    end else begin
      if (prog_req) mode_q <= prog_mode;
      if (wr_stb) begin
        if (!wr_hi) begin
          count[BYTE_W-1:0] <= wr_byte;
          running           <= 1'b0;
          out_pin           <= 1'b0;
          wr_hi             <= 1'b1;
        end else begin
          count[CNT_W-1:BYTE_W] <= wr_byte;
          period                <= full_load;
          running               <= (full_load != ZERO);
          if (full_load != ZERO && mode_q != PM_TC) out_pin <= 1'b1;
          wr_hi <= 1'b0;
        end
      end else if (tick && running) begin
        unique case (mode_q)
          PM_TC: begin
            count <= count - ONE;
            if (count == ONE) begin
              out_pin <= 1'b1;
              running <= 1'b0;
            end
          end
          PM_RATE: begin
            if (count == ONE) begin
              count   <= period;
              out_pin <= 1'b0;
            end else begin
              count   <= count - ONE;
              out_pin <= 1'b1;
            end
          end
          PM_SQW: begin
            if (count <= TWO) begin
              count   <= period;
              out_pin <= ~out_pin;
            end else begin
              count <= count - TWO;
            end
          end
          default: count <= count;
        endcase
      end
    end
  end

endmodule

// File: rtl/pit_readout.sv
module pit_readout #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W,
  localparam int NBYTE = CNT_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_req,
  input  logic              rd_stb,
  input  logic [CNT_W-1:0]  live,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              latched,
  output logic [CNT_W-1:0]  hold_q
);

  logic              rd_hi;
  logic [CNT_W-1:0]  src;
  logic [BYTE_W-1:0] lane [NBYTE];

  assign src = latched ? hold_q : live;

  for (genvar g = 0; g < NBYTE; g++) begin : g_lane
    assign lane[g] = src[g*BYTE_W +: BYTE_W];
  end

  assign rd_byte = rd_hi ? lane[1] : lane[0];

  // a fresh latch takes priority over a read in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_hi   <= 1'b0;
      latched <= 1'b0;
      hold_q  <= '0;
    end else if (latch_req && !latched) begin
      latched <= 1'b1;
      hold_q  <= live;
      rd_hi   <= 1'b0;
    end else if (rd_stb) begin
      if (rd_hi) begin
        rd_hi   <= 1'b0;
        latched <= 1'b0;
      end else begin
        rd_hi <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CHAN_ID = 0,
  parameter int BYTE_W  = PIT_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_tick,
  input  logic              ctrl_wr,
  input  logic [7:0]        ctrl_word,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              out_pin,
  output logic              cfg_err
);

  localparam int CNT_W = 2 * BYTE_W;

  logic             latch_req;
  logic             prog_req;
  pit_mode_e        prog_mode;
  logic             cw_bad;
  logic [CNT_W-1:0] live_count;
  logic             running;
  logic             wr_hi;
  pit_mode_e        mode_q;
  logic             latched;
  logic [CNT_W-1:0] hold_q;

  pit_cw_decode #(.CHAN_ID(CHAN_ID)) u_dec (
    .cw_wr     (ctrl_wr),
    .cw        (pit_cw_t'(ctrl_word)),
    .latch_req (latch_req),
    .prog_req  (prog_req),
    .prog_mode (prog_mode),
    .cw_bad    (cw_bad)
  );

  pit_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (cnt_tick),
    .prog_req  (prog_req),
    .prog_mode (prog_mode),
    .wr_stb    (data_wr),
    .wr_byte   (wr_byte),
    .count     (live_count),
    .out_pin   (out_pin),
    .running   (running),
    .wr_hi     (wr_hi),
    .mode_q    (mode_q)
  );

  pit_readout #(.BYTE_W(BYTE_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch_req (latch_req),
    .rd_stb    (data_rd),
    .live      (live_count),
    .rd_byte   (rd_byte),
    .latched   (latched),
    .hold_q    (hold_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_err <= 1'b0;
    else if (cw_bad) cfg_err <= 1'b1;
  end

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             data_wr,
  input logic             out_pin,
  input logic             cfg_err,
  input logic             wr_hi,
  input logic             running,
  input logic [CNT_W-1:0] count,
  input logic [2:0]       mode,
  input logic             latched,
  input logic [CNT_W-1:0] hold
);

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R4
  low_load_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !wr_hi) |=> (!out_pin && !running && wr_hi));

  // R8
  tc_out_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b000 && out_pin && !data_wr) |=> out_pin);

  // R7
  hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latched |=> (!latched || $stable(hold)));

  // R11
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !data_wr) |=> $stable(count));

endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .data_wr (data_wr),
  .out_pin (out_pin),
  .cfg_err (cfg_err),
  .wr_hi   (wr_hi),
  .running (running),
  .count   (live_count),
  .mode    (mode_q),
  .latched (latched),
  .hold    (hold_q)
);

// File: tb/pit_channel_bench.sv
`timescale 1ns/1ps
module pit_channel_bench;

  localparam int CH = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_tick = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_word = 8'h00;
  logic       data_wr = 1'b0;
  logic       data_rd = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic [7:0] rd_byte;
  logic       out_pin;
  logic       cfg_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the channel
  logic [15:0] m_count, m_period, m_hold;
  logic [2:0]  m_mode;
  logic        m_run, m_out, m_whi, m_rhi, m_lat, m_err;

  always #2.5 clk = ~clk;

  pit_channel #(.CHAN_ID(CH), .BYTE_W(8)) u_pit_channel (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .ctrl_wr(ctrl_wr),
    .ctrl_word(ctrl_word), .data_wr(data_wr), .data_rd(data_rd),
    .wr_byte(wr_byte), .rd_byte(rd_byte), .out_pin(out_pin), .cfg_err(cfg_err)
  );

  function automatic logic [7:0] cw(input logic [1:0] s, input logic [1:0] a,
                                    input logic [2:0] m, input logic b);
    return {s, a, m, b};
  endfunction

  task automatic m_reset();
    m_count = 0; m_period = 0; m_hold = 0; m_mode = 0;
    m_run = 0; m_out = 0; m_whi = 0; m_rhi = 0; m_lat = 0; m_err = 0;
  endtask

  task automatic m_ctrl(input logic [7:0] w);
    if (w[7:6] == 2'(CH)) begin
      if (w[5:4] == 2'b00) begin
        if (!m_lat) begin m_lat = 1; m_hold = m_count; m_rhi = 0; end
      end else if (w[5:4] == 2'b11 && !w[0] &&
                   (w[3:1] == 3'd0 || w[3:1] == 3'd2 || w[3:1] == 3'd3))
        m_mode = w[3:1];
      else m_err = 1;
    end else if (w[7:6] == 2'b11) m_err = 1;
  endtask

  task automatic m_write(input logic [7:0] b);
    if (!m_whi) begin
      m_count[7:0] = b; m_run = 0; m_out = 0; m_whi = 1;
    end else begin
      m_count[15:8] = b; m_period = m_count; m_run = (m_count != 0);
      if (m_run && m_mode != 3'd0) m_out = 1;
      m_whi = 0;
    end
  endtask

  task automatic m_tick();
    if (m_run) begin
      case (m_mode)
        3'd0: begin
          if (m_count == 1) begin m_out = 1; m_run = 0; end
          m_count = m_count - 1;
        end
        3'd2: begin
          if (m_count == 1) begin m_count = m_period; m_out = 0; end
          else begin m_count = m_count - 1; m_out = 1; end
        end
        default: begin
          if (m_count <= 2) begin m_count = m_period; m_out = ~m_out; end
          else m_count = m_count - 2;
        end
      endcase
    end
  endtask

  function automatic logic [7:0] m_peek();
    logic [15:0] s;
    s = m_lat ? m_hold : m_count;
    return m_rhi ? s[15:8] : s[7:0];
  endfunction

  task automatic m_read_adv();
    if (m_rhi) begin m_rhi = 0; m_lat = 0; end
    else m_rhi = 1;
  endtask

  task automatic check(input string tag, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  task automatic chk_pins(input string tag);
    check(tag, "out_pin", {15'd0, out_pin}, {15'd0, m_out});
    check(tag, "cfg_err", {15'd0, cfg_err}, {15'd0, m_err});
  endtask

  task automatic do_ctrl(input logic [7:0] w, input string tag);
    @(negedge clk); ctrl_wr = 1; ctrl_word = w;
    @(negedge clk); ctrl_wr = 0;
    m_ctrl(w); chk_pins(tag);
  endtask

  task automatic do_wr(input logic [7:0] b, input string tag);
    @(negedge clk); data_wr = 1; wr_byte = b;
    @(negedge clk); data_wr = 0;
    m_write(b); chk_pins(tag);
  endtask

  task automatic do_tick(input string tag);
    @(negedge clk); cnt_tick = 1;
    @(negedge clk); cnt_tick = 0;
    m_tick(); chk_pins(tag);
  endtask

  task automatic do_rd(input string tag);
    @(negedge clk); data_rd = 1;
    #1 check(tag, "rd_byte", {8'd0, rd_byte}, {8'd0, m_peek()});
    @(negedge clk); data_rd = 0;
    m_read_adv();
  endtask

  task automatic load16(input logic [15:0] v, input string tag);
    do_wr(v[7:0], tag);
    do_wr(v[15:8], tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk_pins("R1");
    do_rd("R1"); do_rd("R1");

    // R2 / R5 / R6 mode 0 load and live read
    do_ctrl(cw(2'(CH), 2'b11, 3'd0, 1'b0), "R2");
    load16(16'h0005, "R5");
    do_rd("R6"); do_rd("R6");
    // R8 terminal count
    repeat (5) do_tick("R8");
    repeat (3) do_tick("R8");
    do_rd("R8"); do_rd("R8");

    // R4 / R12 low byte write stops, reads between load bytes
    do_wr(8'h03, "R4");
    do_rd("R12");
    do_wr(8'h00, "R12");
    do_rd("R12");
    repeat (2) do_tick("R12");

    // R7 latch, second latch ignored, release on high read
    load16(16'h1234, "R7");
    do_ctrl(cw(2'(CH), 2'b00, 3'd0, 1'b0), "R7");
    repeat (3) do_tick("R7");
    do_ctrl(cw(2'(CH), 2'b00, 3'd0, 1'b0), "R7");
    do_rd("R7"); do_rd("R7"); do_rd("R7"); do_rd("R7");

    // R11 no enable, no change
    repeat (10) begin @(negedge clk); end
    do_rd("R11"); do_rd("R11");

    // R9 rate generator
    do_ctrl(cw(2'(CH), 2'b11, 3'd2, 1'b0), "R9");
    load16(16'h0003, "R9");
    repeat (8) do_tick("R9");

    // R10 square wave, odd then even period
    do_ctrl(cw(2'(CH), 2'b11, 3'd3, 1'b0), "R10");
    load16(16'h0005, "R10");
    repeat (9) do_tick("R10");
    load16(16'h0004, "R10");
    repeat (7) do_tick("R10");

    // R5 zero load does not start
    load16(16'h0000, "R5");
    repeat (3) do_tick("R5");
    do_rd("R5"); do_rd("R5");

    // R2 other channel words ignored without error
    do_ctrl(cw(2'd0, 2'b11, 3'd0, 1'b0), "R2");
    do_ctrl(cw(2'd1, 2'b00, 3'd0, 1'b0), "R2");
    do_rd("R2"); do_rd("R2");

    // R3 invalid words ignored, flag sticky; mode stays square wave
    do_ctrl(cw(2'(CH), 2'b01, 3'd0, 1'b0), "R3");
    do_ctrl(cw(2'(CH), 2'b11, 3'd5, 1'b0), "R3");
    do_ctrl(cw(2'(CH), 2'b11, 3'd0, 1'b1), "R3");
    do_ctrl(cw(2'b11, 2'b11, 3'd0, 1'b0), "R3");
    load16(16'h0006, "R3");
    repeat (5) do_tick("R3");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 100;
      if (r < 10) begin
        int k;
        k = $urandom % 10;
        if (k < 5) begin
          logic [2:0] md;
          md = (k == 0) ? 3'd0 : ((k < 3) ? 3'd2 : 3'd3);
          do_ctrl(cw(2'(CH), 2'b11, md, 1'b0), "R2");
        end else if (k < 7) do_ctrl(cw(2'(CH), 2'b00, 3'd0, 1'b0), "R7");
        else do_ctrl(8'($urandom), "R3");
      end else if (r < 30) begin
        do_wr(($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 9), "R5");
      end else if (r < 45) begin
        do_rd("R6");
      end else begin
        do_tick("R11");
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule